// File: doc/BRIEF.md
# Reference-Locked Oscillator Trim Controller

This block tunes a fast on-chip oscillator against a slow reference. A counter runs on the oscillator clock. It is loaded with a programmed reload value each time a reference sync event arrives, counts down to zero, and then counts up. When the next sync event arrives, the counter value and its counting direction are captured. The captured value shows how far the oscillator has drifted.

Each capture is sorted into one of three windows set by an 8-bit limit:
- inside the limit, which reports the clock as good;
- inside three times the limit, which gives a warning and, in automatic mode, nudges a 6-bit trim code one step;
- beyond that, which is a hard error.

A sync event comes from one of three hardware strobes, or from a software pulse. The hardware strobe goes through a polarity-selectable edge detector and a power-of-two edge prescaler. All inputs are synchronous to the oscillator clock. Sticky status flags, each with an enable and a clear, are folded into a single interrupt line.

Top module: `osc_trim_ctrl`

## Requirements
- R1: `ref_src` selects the hardware reference: 0 = `ref_pin`, 1 = `ref_xtal`, 2 = `ref_sof`, 3 = no hardware source. Only the selected input can create an event. With `ref_pol`=1 a 0→1 change of the selected input is an edge; with `ref_pol`=0 a 1→0 change is an edge. The previous-value register resets to 0.
- R2: Selected edges are counted, and every 2^`ref_psc`-th edge (`ref_psc` 0..7, so divide by 1..128) becomes a hardware event. The edge count restarts after each event.
- R3: A one-cycle `sw_pulse` is a sync event regardless of `ref_src`.
- R4: On the first cycle with `cnt_en` high, the counter loads `reload_val` and counts down. In a cycle where it holds 0 while counting down, expect-reference is set and it turns to counting up from 1. Up-counting saturates at all ones. While `cnt_en` is low, or on the start cycle, sync events are ignored and the counter holds.
- R5: At a sync event while running, `cap_value` takes the counter value and `cap_dir` takes the direction (1 = down, 0 = up). The counter then reloads and counts down.
- R6: A capture ≤ `limit_val` sets OK. A capture above that but ≤ 3×`limit_val` sets warning. A larger capture sets the clock-error cause (`err_cause` bit 0).
- R7: On a warning with `auto_trim`=1, `trim_code` steps +1 if the capture was taken down-counting, and −1 if taken up-counting. With `auto_trim`=0 it changes only through `trim_wr`, which loads `trim_wdata` and takes priority over any step.
- R8: A step that would leave 0x00..0x3F leaves `trim_code` unchanged and sets the trim-error cause (`err_cause` bit 2).
- R9: While counting up with no sync event, a counter value above 3×`limit_val` sets the missed-reference cause (`err_cause` bit 1).
- R10: Flags are sticky. `flag_err` is the OR of the three causes. `flag_clr` bit 0 clears OK, bit 1 clears warning, bit 2 clears all three causes, bit 3 clears expect-reference. A set in the same cycle wins over a clear.
- R11: `irq` is high when any flag is high together with its `irq_en` bit: 0 = OK, 1 = warning, 2 = error, 3 = expect-reference.
- R12: After reset `trim_code` is 0x20, and all flags, causes, `cap_value`, `cap_dir` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Runs the trim counter |
| auto_trim | input | 1 | Enables hardware trim stepping |
| ref_src | input | 2 | Hardware reference select |
| ref_pol | input | 1 | 1 = rising edge, 0 = falling edge |
| ref_psc | input | 3 | Edge prescaler exponent |
| reload_val | input | 16 | Counter reload value |
| limit_val | input | 8 | Classification limit |
| ref_pin | input | 1 | External pin reference strobe |
| ref_xtal | input | 1 | Low-speed crystal reference strobe |
| ref_sof | input | 1 | USB start-of-frame strobe |
| sw_pulse | input | 1 | Software sync event |
| trim_wr | input | 1 | Software trim write strobe |
| trim_wdata | input | 6 | Software trim value |
| irq_en | input | 4 | Interrupt enables |
| flag_clr | input | 4 | Flag clear strobes |
| trim_code | output | 6 | Current trim code |
| cap_value | output | 16 | Captured counter value |
| cap_dir | output | 1 | Captured direction, 1 = down |
| flag_ok | output | 1 | Clock within limit |
| flag_warn | output | 1 | Clock within warning window |
| flag_err | output | 1 | Any error cause present |
| flag_eref | output | 1 | Down-count reached zero |
| err_cause | output | 3 | Clock error, missed reference, trim error |
| irq | output | 1 | Enabled-flag interrupt |

## Verification
The bench builds the block with its default widths: a 16-bit counter, an 8-bit limit and a 6-bit trim code. At run time it uses a reload of 40 and a limit of 4, so every window, the turn-around at zero and the missed-reference threshold at 13 fall within a few dozen cycles of each other. It writes the trim code to 0x3F and to 0x00 to push automatic steps against both ends of the range. It also selects a divide-by-4 prescale and the falling polarity, so those paths are exercised without long waits.

// File: rtl/osc_trim_pkg.sv
// Shared encodings for the oscillator trim controller.
package osc_trim_pkg;
    typedef enum logic [1:0] {
        SRC_PIN  = 2'd0,
        SRC_XTAL = 2'd1,
        SRC_SOF  = 2'd2,
        SRC_NONE = 2'd3
    } ref_src_e;

    localparam int unsigned FLG_OK   = 0;
    localparam int unsigned FLG_WARN = 1;
    localparam int unsigned FLG_ERR  = 2;
    localparam int unsigned FLG_EREF = 3;
    localparam int unsigned NUM_FLG  = 4;

    localparam int unsigned CAUSE_CLK  = 0;
    localparam int unsigned CAUSE_MISS = 1;
    localparam int unsigned CAUSE_TRIM = 2;
    localparam int unsigned NUM_CAUSE  = 3;
endpackage

// File: rtl/ref_event_gen.sv
// Selects a hardware strobe, detects the chosen edge, and divides edges by a
// power of two. Assumes all strobes are already synchronous to clk.
module ref_event_gen
    import osc_trim_pkg::*;
#(
    parameter int unsigned PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src,
    input  logic             pol,
    input  logic [PSC_W-1:0] psc,
    input  logic             in_pin,
    input  logic             in_xtal,
    input  logic             in_sof,
    output logic             hw_evt
);
    localparam int unsigned DIV_MAX = (1 << ((1 << PSC_W) - 1));
    localparam int unsigned DCNT_W  = $clog2(DIV_MAX) + 1;

    logic              sel;
    logic              prev_q;
    logic              edge_det;
    logic [DCNT_W-1:0] div_q;
    logic [DCNT_W-1:0] div_mask;

    // Route the selected strobe.
    always_comb begin
        unique case (ref_src_e'(src))
            SRC_PIN:  sel = in_pin;
            SRC_XTAL: sel = in_xtal;
            SRC_SOF:  sel = in_sof;
            default:  sel = 1'b0;
        endcase
    end

    // Remember last strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sel;
    end

    // Edge of the requested polarity and terminal count of the divider.
    always_comb begin
        edge_det = pol ? (sel & ~prev_q) : (~sel & prev_q);
        div_mask = DCNT_W'((DIV_MAX'(1) << psc) - 1);
        hw_evt   = edge_det && (div_q >= div_mask);
    end

    // Count edges, wrapping at each produced event.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= '0;
        else if (hw_evt)   div_q <= '0;
        else if (edge_det) div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/trim_counter.sv
// Reload counter: loads, counts down to zero, then up; captures value and
// direction on each sync event and classifies the capture against the limit.
// Assumes CNT_W is at least LIM_W + 2 so three times the limit fits.
module trim_counter #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             sync_raw,
    input  logic [CNT_W-1:0] reload,
    input  logic [LIM_W-1:0] limit,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_dir,
    output logic             hit_ok,
    output logic             hit_warn,
    output logic             hit_err,
    output logic             warn_early,
    output logic             hit_zero,
    output logic             hit_miss
);
    localparam int unsigned WIN_W = LIM_W + 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             run_q;
    logic             dir_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start;
    logic             running;
    logic             sync;
    logic [CNT_W-1:0] lim_ext;
    logic [CNT_W-1:0] win_ext;

    // Decode the start cycle, running state and gated sync.
    always_comb begin
        start   = cnt_en & ~run_q;
        running = cnt_en & run_q;
        sync    = sync_raw & running;
        lim_ext = CNT_W'(limit);
        win_ext = CNT_W'(WIN_W'(limit) * WIN_W'(3));
    end

    // Track the enable one cycle late to find the start cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= cnt_en;
    end

    // Counter value and direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b1;
        end else if (start || sync) begin
            cnt_q <= reload;
            dir_q <= 1'b1;
        end else if (running) begin
            if (dir_q) begin
                if (cnt_q == '0) begin
                    dir_q <= 1'b0;
                    cnt_q <= CNT_W'(1);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Capture register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_value <= '0;
            cap_dir   <= 1'b0;
        end else if (sync) begin
            cap_value <= cnt_q;
            cap_dir   <= dir_q;
        end
    end

    // Classify the live counter value at a sync event.
    always_comb begin
        hit_ok     = sync && (cnt_q <= lim_ext);
        hit_warn   = sync && (cnt_q > lim_ext) && (cnt_q <= win_ext);
        hit_err    = sync && (cnt_q > win_ext);
        warn_early = dir_q;
        hit_zero   = running && !sync && dir_q && (cnt_q == '0);
        hit_miss   = running && !sync && !dir_q && (cnt_q > win_ext);
    end
endmodule

// File: rtl/trim_stepper.sv
// Holds the trim code: software load, or one-step hardware adjustment on a
// warning, saturating at the range ends and reporting the blocked step.
module trim_stepper #(
    parameter int unsigned TRIM_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_trim,
    input  logic              wr,
    input  logic [TRIM_W-1:0] wdata,
    input  logic              warn,
    input  logic              early,
    output logic [TRIM_W-1:0] code,
    output logic              step_fault
);
    localparam logic [TRIM_W-1:0] CODE_MID = TRIM_W'(1 << (TRIM_W - 1));
    localparam logic [TRIM_W-1:0] CODE_TOP = '1;

    logic step_up;
    logic step_dn;

    // Decide whether a hardware step is requested and whether it is legal.
    always_comb begin
        step_up    = auto_trim && !wr && warn && early;
        step_dn    = auto_trim && !wr && warn && !early;
        step_fault = (step_up && code == CODE_TOP) || (step_dn && code == '0);
    end

    // Update the trim code.
    always_ff @(posedge clk) begin
        if (!rst_n)                          code <= CODE_MID;
        else if (wr)                         code <= wdata;
        else if (step_up && code != CODE_TOP) code <= code + 1'b1;
        else if (step_dn && code != '0)       code <= code - 1'b1;
    end
endmodule

// File: rtl/flag_bank.sv
// Sticky status flags with per-flag clear, shared error clear and enables.
// A set in the same cycle as a clear wins.
module flag_bank
    import osc_trim_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_ok,
    input  logic                 set_warn,
    input  logic                 set_eref,
    input  logic [NUM_CAUSE-1:0] set_cause,
    input  logic [NUM_FLG-1:0]   clr,
    input  logic [NUM_FLG-1:0]   ien,
    output logic [NUM_FLG-1:0]   flags,
    output logic [NUM_CAUSE-1:0] cause,
    output logic                 irq
);
    logic [NUM_FLG-1:0] simple_q;

    // Independent flags: OK, warning, expect-reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            simple_q <= '0;
        end else begin
            simple_q[FLG_OK]   <= set_ok   | (simple_q[FLG_OK]   & ~clr[FLG_OK]);
            simple_q[FLG_WARN] <= set_warn | (simple_q[FLG_WARN] & ~clr[FLG_WARN]);
            simple_q[FLG_EREF] <= set_eref | (simple_q[FLG_EREF] & ~clr[FLG_EREF]);
            simple_q[FLG_ERR]  <= 1'b0;
        end
    end

    // Error causes share one clear bit.
    for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_cause
        always_ff @(posedge clk) begin
            if (!rst_n) cause[i] <= 1'b0;
            else        cause[i] <= set_cause[i] | (cause[i] & ~clr[FLG_ERR]);
        end
    end

    // Assemble the flag vector and the interrupt.
    always_comb begin
        flags          = simple_q;
        flags[FLG_ERR] = |cause;
        irq            = |(flags & ien);
    end
endmodule

// File: rtl/osc_trim_ctrl.sv
// Top of the oscillator trim controller. Assumes every input is synchronous
// to the oscillator clock and that control fields are static or change
// between events.
module osc_trim_ctrl
    import osc_trim_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned LIM_W  = 8,
    parameter int unsigned TRIM_W = 6,
    parameter int unsigned PSC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              auto_trim,
    input  logic [1:0]        ref_src,
    input  logic              ref_pol,
    input  logic [PSC_W-1:0]  ref_psc,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic [LIM_W-1:0]  limit_val,
    input  logic              ref_pin,
    input  logic              ref_xtal,
    input  logic              ref_sof,
    input  logic              sw_pulse,
    input  logic              trim_wr,
    input  logic [TRIM_W-1:0] trim_wdata,
    input  logic [3:0]        irq_en,
    input  logic [3:0]        flag_clr,
    output logic [TRIM_W-1:0] trim_code,
    output logic [CNT_W-1:0]  cap_value,
    output logic              cap_dir,
    output logic              flag_ok,
    output logic              flag_warn,
    output logic              flag_err,
    output logic              flag_eref,
    output logic [2:0]        err_cause,
    output logic              irq
);
    logic               hw_evt;
    logic               sync_raw;
    logic               hit_ok, hit_warn, hit_err, warn_early, hit_zero, hit_miss;
    logic               trim_fault;
    logic [NUM_FLG-1:0] flags;

    // Software pulse joins the hardware event path.
    assign sync_raw = hw_evt | sw_pulse;

    ref_event_gen #(.PSC_W(PSC_W)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (ref_src),
        .pol     (ref_pol),
        .psc     (ref_psc),
        .in_pin  (ref_pin),
        .in_xtal (ref_xtal),
        .in_sof  (ref_sof),
        .hw_evt  (hw_evt)
    );

    trim_counter #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .sync_raw   (sync_raw),
        .reload     (reload_val),
        .limit      (limit_val),
        .cap_value  (cap_value),
        .cap_dir    (cap_dir),
        .hit_ok     (hit_ok),
        .hit_warn   (hit_warn),
        .hit_err    (hit_err),
        .warn_early (warn_early),
        .hit_zero   (hit_zero),
        .hit_miss   (hit_miss)
    );

    trim_stepper #(.TRIM_W(TRIM_W)) u_trim (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_trim  (auto_trim),
        .wr         (trim_wr),
        .wdata      (trim_wdata),
        .warn       (hit_warn),
        .early      (warn_early),
        .code       (trim_code),
        .step_fault (trim_fault)
    );

    flag_bank u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_ok    (hit_ok),
        .set_warn  (hit_warn),
        .set_eref  (hit_zero),
        .set_cause ({trim_fault, hit_miss, hit_err}),
        .clr       (flag_clr),
        .ien       (irq_en),
        .flags     (flags),
        .cause     (err_cause),
        .irq       (irq)
    );

    assign flag_ok   = flags[FLG_OK];
    assign flag_warn = flags[FLG_WARN];
    assign flag_err  = flags[FLG_ERR];
    assign flag_eref = flags[FLG_EREF];
endmodule

// File: rtl/osc_trim_ctrl_chk.sv
// Port-level temporal checks for the trim controller, bound to the top.
module osc_trim_ctrl_chk #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned TRIM_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_en,
    input logic              auto_trim,
    input logic              trim_wr,
    input logic [3:0]        irq_en,
    input logic [3:0]        flag_clr,
    input logic [TRIM_W-1:0] trim_code,
    input logic [CNT_W-1:0]  cap_value,
    input logic              cap_dir,
    input logic              flag_ok,
    input logic              flag_err,
    input logic              irq
);
    // R7: without a write the code moves by at most one per cycle
    p_trim_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !trim_wr |=> ($stable(trim_code) ||
                      trim_code == $past(trim_code) + TRIM_W'(1) ||
                      trim_code == $past(trim_code) - TRIM_W'(1)));

    // R7: manual mode leaves the code alone
    p_manual_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_trim && !trim_wr) |=> $stable(trim_code));

    // R4: no capture while the counter is disabled
    p_idle_no_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> ($stable(cap_value) && $stable(cap_dir)));

    // R10: error stays until its clear
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_err && !flag_clr[2]) |=> flag_err);

    // R11: no interrupt when nothing is enabled
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 4'd0) |-> !irq);

    // R6: OK can only appear while counting is enabled
    p_ok_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_ok) |-> $past(cnt_en));
endmodule

bind osc_trim_ctrl osc_trim_ctrl_chk #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .auto_trim (auto_trim),
    .trim_wr   (trim_wr),
    .irq_en    (irq_en),
    .flag_clr  (flag_clr),
    .trim_code (trim_code),
    .cap_value (cap_value),
    .cap_dir   (cap_dir),
    .flag_ok   (flag_ok),
    .flag_err  (flag_err),
    .irq       (irq)
);

// File: tb/tb_osc_trim_ctrl.sv
module tb_osc_trim_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 0, auto_trim = 0, ref_pol = 1;
    logic [1:0]  ref_src = 0;
    logic [2:0]  ref_psc = 0;
    logic [15:0] reload_val = 0;
    logic [7:0]  limit_val = 0;
    logic        ref_pin = 0, ref_xtal = 0, ref_sof = 0, sw_pulse = 0, trim_wr = 0;
    logic [5:0]  trim_wdata = 0;
    logic [3:0]  irq_en = 0, flag_clr = 0;
    logic [5:0]  trim_code;
    logic [15:0] cap_value;
    logic        cap_dir, flag_ok, flag_warn, flag_err, flag_eref, irq;
    logic [2:0]  err_cause;

    always #4 clk = ~clk;

    osc_trim_ctrl dut (.*);

    int    n_chk = 0, n_bad = 0, cycles = 0;
    bit    done = 0;
    string phase = "R12";

    // behavioural reference state
    int m_prev, m_psc, m_run, m_cnt, m_dir, m_cap, m_capdir, m_trim;
    int m_ok, m_warn, m_eref, m_ck, m_miss, m_terr;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Reference model update, then comparison once outputs settle.
    always @(posedge clk) begin
        int sel, edge_s, evt, mask, run_ok, start, sync, win3, st_ok, st_warn, st_eref, st_ck, st_miss, st_terr;
        cycles++;
        if (!rst_n) begin
            m_prev = 0; m_psc = 0; m_run = 0; m_cnt = 0; m_dir = 1; m_cap = 0; m_capdir = 0;
            m_trim = 32; m_ok = 0; m_warn = 0; m_eref = 0; m_ck = 0; m_miss = 0; m_terr = 0;
        end else begin
            sel = (ref_src == 0) ? ref_pin : (ref_src == 1) ? ref_xtal : (ref_src == 2) ? ref_sof : 0;
            edge_s = ref_pol ? (sel == 1 && m_prev == 0) : (sel == 0 && m_prev == 1);
            m_prev = sel;
            evt = 0;
            if (edge_s) begin
                mask = (1 << ref_psc) - 1;
                if (m_psc >= mask) begin evt = 1; m_psc = 0; end
                else m_psc++;
            end
            run_ok = cnt_en && m_run;
            start  = cnt_en && !m_run;
            m_run  = cnt_en;
            sync   = run_ok && (evt || sw_pulse);
            win3   = 3 * limit_val;
            st_ok = 0; st_warn = 0; st_eref = 0; st_ck = 0; st_miss = 0; st_terr = 0;
            if (start) begin
                m_cnt = reload_val; m_dir = 1;
            end else if (sync) begin
                m_cap = m_cnt; m_capdir = m_dir;
                if (m_cnt <= limit_val) st_ok = 1;
                else if (m_cnt <= win3) begin
                    st_warn = 1;
                    if (auto_trim && !trim_wr) begin
                        if (m_dir == 1) begin
                            if (m_trim == 63) st_terr = 1; else m_trim++;
                        end else begin
                            if (m_trim == 0) st_terr = 1; else m_trim--;
                        end
                    end
                end else st_ck = 1;
                m_cnt = reload_val; m_dir = 1;
            end else if (run_ok) begin
                if (m_dir == 1) begin
                    if (m_cnt == 0) begin st_eref = 1; m_dir = 0; m_cnt = 1; end
                    else m_cnt--;
                end else begin
                    if (m_cnt > win3) st_miss = 1;
                    if (m_cnt < 65535) m_cnt++;
                end
            end
            if (trim_wr) m_trim = trim_wdata;
            m_ok   = st_ok   || (m_ok   && !flag_clr[0]);
            m_warn = st_warn || (m_warn && !flag_clr[1]);
            m_eref = st_eref || (m_eref && !flag_clr[3]);
            m_ck   = st_ck   || (m_ck   && !flag_clr[2]);
            m_miss = st_miss || (m_miss && !flag_clr[2]);
            m_terr = st_terr || (m_terr && !flag_clr[2]);
        end
        #2;
        begin
            int err_e, irq_e;
            err_e = m_ck || m_miss || m_terr;
            irq_e = (m_ok && irq_en[0]) || (m_warn && irq_en[1]) || (err_e && irq_en[2]) || (m_eref && irq_en[3]);
            chk({"R7 R8 ", phase}, "trim_code", trim_code, m_trim);
            chk({"R5 ", phase}, "cap_value", cap_value, m_cap);
            chk({"R5 ", phase}, "cap_dir", cap_dir, m_capdir);
            chk("R6", "flag_ok", flag_ok, m_ok);
            chk("R6", "flag_warn", flag_warn, m_warn);
            chk("R6", "clock error cause", err_cause[0], m_ck);
            chk("R9", "missed ref cause", err_cause[1], m_miss);
            chk("R8", "trim error cause", err_cause[2], m_terr);
            chk("R4", "flag_eref", flag_eref, m_eref);
            chk("R10", "flag_err", flag_err, err_e);
            chk("R11", "irq", irq, irq_e);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
            finish_run();
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // One strobe on the chosen line, next one d cycles later.
    task automatic strobe(int which, int d);
        logic idle;
        idle = ref_pol ? 1'b0 : 1'b1;
        case (which)
            0: ref_pin  = ~idle;
            1: ref_xtal = ~idle;
            default: ref_sof = ~idle;
        endcase
        tick(1);
        case (which)
            0: ref_pin  = idle;
            1: ref_xtal = idle;
            default: ref_sof = idle;
        endcase
        tick(d - 1);
    endtask

    task automatic swp(int d);
        sw_pulse = 1; tick(1); sw_pulse = 0; tick(d - 1);
    endtask

    task automatic clear_all();
        flag_clr = 4'hF; tick(1); flag_clr = 4'h0;
    endtask

    initial begin
        tick(4);
        // R12 reset values
        chk("R12", "reset trim_code", trim_code, 32);
        chk("R12", "reset irq", irq, 0);
        chk("R12", "reset flags", {flag_ok, flag_warn, flag_err, flag_eref, err_cause}, 0);
        rst_n = 1;
        reload_val = 40; limit_val = 4; auto_trim = 1; irq_en = 4'hF;
        ref_src = 0; ref_pol = 1; ref_psc = 0;
        tick(2);
        phase = "R4";
        cnt_en = 1;
        strobe(0, 39);                 // ok, down
        phase = "R1";
        strobe(0, 30);                 // warn early, trim up
        strobe(0, 45);                 // ok, up (eref on the way)
        strobe(0, 50);                 // warn late, trim down
        strobe(0, 60);                 // missed ref then clock error
        strobe(0, 35);
        strobe(0, 20);                 // clock error early
        strobe(0, 10);
        clear_all();
        // R2 prescaler divide by 4
        phase = "R2";
        ref_psc = 2;
        repeat (12) strobe(0, 10);
        ref_psc = 0;
        // R1 falling polarity
        phase = "R1";
        ref_pol = 0; ref_pin = 1; tick(3);
        strobe(0, 38); strobe(0, 31); strobe(0, 44);
        ref_pol = 1; ref_pin = 0; tick(2);
        // R1 other sources; pin toggling ignored
        ref_src = 1;
        strobe(0, 20); strobe(1, 39); strobe(0, 15); strobe(1, 32);
        ref_src = 2;
        strobe(1, 20); strobe(2, 36); strobe(2, 48);
        // R3 software pulse with no hardware source
        phase = "R3";
        ref_src = 3;
        strobe(0, 20); swp(39); swp(29); swp(52);
        clear_all();
        // R8 saturation at both ends
        phase = "R8";
        trim_wdata = 6'h3F; trim_wr = 1; tick(1); trim_wr = 0;
        swp(30); swp(30);
        trim_wdata = 6'h00; trim_wr = 1; tick(1); trim_wr = 0;
        swp(50); swp(50);
        // R7 manual mode
        phase = "R7";
        auto_trim = 0;
        swp(30); swp(50);
        // R10 set wins over clear, R11 masking
        phase = "R10";
        irq_en = 4'h0; swp(10); clear_all();
        irq_en = 4'b0010; swp(30); tick(5);
        flag_clr = 4'b0010; tick(1); flag_clr = 0;
        irq_en = 4'b1000; tick(50);
        // R4 disabled counter ignores events
        phase = "R4";
        cnt_en = 0; tick(2); swp(20); ref_src = 0; strobe(0, 20);
        cnt_en = 1; tick(70);
        finish_run();
    end
endmodule